// File: doc/BRIEF.md
# Video Sample Range Limiter

This block sits in front of a video encoder and keeps every 8-bit luma or chroma sample inside its legal coding range. Each sample arrives with a component select (luma or chroma) and a valid strobe. If a sample lies below the active lower limit, the block replaces it with that lower limit. If it lies above the active upper limit, the block replaces it with that upper limit. The two codes at the ends of the 8-bit scale are kept for synchronization, so the output never carries them.

A wide-range control extends both components to the near-full scale, for systems that carry signal excursions above white and below black. The block samples this control only on a line-start strobe, so the range cannot change partway through a line. A vertical-blanking pass-through flag lets ancillary data go through without range limiting. The only change it still makes is to remap the two sync codes onto their nearest neighbours. The result is registered, and the output valid strobe is delayed to match.

Top module: `vid_range_limiter`

## Requirements
- R1: In narrow mode (wide mode inactive, pass-through clear), a luma sample (`in_chroma`=0) is limited to 0x10..0xEB. Values in that range pass unchanged, values below become 0x10 and values above become 0xEB.
- R2: In narrow mode, a chroma sample (`in_chroma`=1) is limited to 0x10..0xF0. Values in that range pass unchanged, values below become 0x10 and values above become 0xF0.
- R3: In wide mode with pass-through clear, both components are limited to 0x01..0xFE. 0x00 becomes 0x01, 0xFF becomes 0xFE, and all other values pass unchanged.
- R4: When `in_vbi_pass`=1, the sample is output unchanged whatever the mode and component, except that 0x00 becomes 0x01 and 0xFF becomes 0xFE.
- R5: `out_sample` never equals 0x00 or 0xFF.
- R6: A sample accepted with `in_valid`=1 at a rising clock edge appears on `out_sample` after that edge. `out_valid` equals `in_valid` delayed by one clock.
- R7: When `in_valid`=0 at an edge, `out_sample` keeps its value.
- R8: The wide-mode state loads `cfg_wide` only in a cycle with `line_start`=1. A sample presented in that same cycle already uses the new value. A change of `cfg_wide` without `line_start` has no effect on the output.
- R9: After a synchronous active-low reset, `out_valid`=0, `out_sample`=0x10, and the mode is narrow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | 8 | Input sample code |
| in_chroma | input | 1 | 1 = chroma (Cb/Cr), 0 = luma |
| in_vbi_pass | input | 1 | Bypass range limiting for blanking-interval data |
| cfg_wide | input | 1 | Requested wide-range mode, taken at line start |
| line_start | input | 1 | Line boundary strobe; loads `cfg_wide` |
| out_valid | output | 1 | Output strobe, `in_valid` delayed one clock |
| out_sample | output | 8 | Range-limited sample |

## Verification
The range assertions assume that the component select, the pass-through flag and the line-start strobe are steady around the edge at which `in_valid` is sampled. They relate the registered output to those inputs one cycle earlier. They also rely on `line_start` being the only way the mode changes. The bench changes every input on the falling edge and holds it through the next rising edge. It asserts `line_start` together with `cfg_wide` whenever a vector needs a particular mode, and it changes `cfg_wide` alone only in the directed test that checks that such a change has no effect.

// File: rtl/vid_range_pkg.sv
// Package: shared sample width, bound type and default range limits for the
// video range limiter. Assumes 8-bit component samples.
package vid_range_pkg;
    localparam int SAMPLE_W = 8;

    typedef logic [SAMPLE_W-1:0] sample_t;

    // Lower and upper limit of one active range.
    typedef struct packed {
        sample_t lo;
        sample_t hi;
    } bounds_t;

    localparam sample_t SYNC_LO_CODE = '0;
    localparam sample_t SYNC_HI_CODE = '1;
    localparam sample_t RESET_CODE   = 8'h10;
endpackage

// File: rtl/vid_range_mode.sv
// Module: holds the wide-range mode. It loads the requested mode only at a line
// boundary and shows the effective mode to the current sample.
// Assumes line_start is a single-cycle strobe at the first sample of a line.
module vid_range_mode (
    input  logic clk,
    input  logic rst_n,
    input  logic line_start,
    input  logic cfg_wide,
    output logic wide_eff
);
    logic wide_q;

    // Purpose: capture the requested mode at each line boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wide_q <= 1'b0;
        else if (line_start)
            wide_q <= cfg_wide;
    end

    // Purpose: a sample in the line-start cycle already sees the new mode.
    always_comb begin
        wide_eff = line_start ? cfg_wide : wide_q;
    end

    // The held mode moves only on a line boundary.
    assert_mode_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !line_start |=> $stable(wide_q));
endmodule

// File: rtl/vid_range_bounds.sv
// Module: selects the active lower and upper limits from the component and the
// mode. Assumes every limit lies strictly between the two sync codes.
module vid_range_bounds
    import vid_range_pkg::*;
#(
    parameter sample_t LUMA_LO   = 8'h10,
    parameter sample_t LUMA_HI   = 8'hEB,
    parameter sample_t CHROMA_LO = 8'h10,
    parameter sample_t CHROMA_HI = 8'hF0,
    parameter sample_t WIDE_LO   = 8'h01,
    parameter sample_t WIDE_HI   = 8'hFE
) (
    input  logic    is_chroma,
    input  logic    wide,
    output bounds_t bounds
);
    localparam bounds_t LUMA_B   = '{lo: LUMA_LO,   hi: LUMA_HI};
    localparam bounds_t CHROMA_B = '{lo: CHROMA_LO, hi: CHROMA_HI};
    localparam bounds_t WIDE_B   = '{lo: WIDE_LO,   hi: WIDE_HI};

    // Purpose: wide mode overrides the per-component limits.
    always_comb begin
        if (wide)
            bounds = WIDE_B;
        else if (is_chroma)
            bounds = CHROMA_B;
        else
            bounds = LUMA_B;
    end
endmodule

// File: rtl/vid_range_clamp.sv
// Module: saturates one sample to the given bounds or, in pass-through, only
// remaps the two sync codes. Purely combinational.
// Assumes bounds.lo <= bounds.hi.
module vid_range_clamp
    import vid_range_pkg::*;
(
    input  sample_t din,
    input  logic    pass,
    input  bounds_t bounds,
    output sample_t dout
);
    localparam sample_t SYNC_LO_NEXT = SYNC_LO_CODE + 1'b1;
    localparam sample_t SYNC_HI_NEXT = SYNC_HI_CODE - 1'b1;

    logic below, above;

    // Purpose: compare the sample against both limits.
    always_comb begin
        below = din < bounds.lo;
        above = din > bounds.hi;
    end

    // Purpose: choose the violated limit, the remapped sync code or the input.
    always_comb begin
        if (pass) begin
            if (din == SYNC_LO_CODE)
                dout = SYNC_LO_NEXT;
            else if (din == SYNC_HI_CODE)
                dout = SYNC_HI_NEXT;
            else
                dout = din;
        end else if (below)
            dout = bounds.lo;
        else if (above)
            dout = bounds.hi;
        else
            dout = din;
    end
endmodule

// File: rtl/vid_range_limiter.sv
// Module: top of the video range limiter. It latches the mode at a line start,
// selects the limits, saturates the sample and registers it with valid.
// Assumes inputs are synchronous to clk; one cycle of latency.
module vid_range_limiter
    import vid_range_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_sample,
    input  logic       in_chroma,
    input  logic       in_vbi_pass,
    input  logic       cfg_wide,
    input  logic       line_start,
    output logic       out_valid,
    output logic [7:0] out_sample
);
    logic    wide_eff;
    bounds_t bounds;
    sample_t clamped;

    vid_range_mode u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_start (line_start),
        .cfg_wide   (cfg_wide),
        .wide_eff   (wide_eff)
    );

    vid_range_bounds u_bounds (
        .is_chroma (in_chroma),
        .wide      (wide_eff),
        .bounds    (bounds)
    );

    vid_range_clamp u_clamp (
        .din    (in_sample),
        .pass   (in_vbi_pass),
        .bounds (bounds),
        .dout   (clamped)
    );

    // Purpose: register the limited sample and align valid with it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_sample <= RESET_CODE;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                out_sample <= clamped;
        end
    end

    assert_luma_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_vbi_pass && !wide_eff && !in_chroma)
        |=> (out_sample >= 8'h10 && out_sample <= 8'hEB));

    assert_chroma_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_vbi_pass && !wide_eff && in_chroma)
        |=> (out_sample >= 8'h10 && out_sample <= 8'hF0));

    assert_wide_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_vbi_pass && wide_eff && in_sample != 8'h00 && in_sample != 8'hFF)
        |=> (out_sample == $past(in_sample)));

    assert_pass_through_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_vbi_pass && in_sample != 8'h00 && in_sample != 8'hFF)
        |=> (out_sample == $past(in_sample)));

    assert_no_sync_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sample != 8'h00 && out_sample != 8'hFF));

    assert_valid_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_valid_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_sample));
endmodule

// File: tb/vid_range_limiter_bench.sv
// Bench: walks a vector table, then runs directed tests for reset, mode timing
// and idle hold.
module vid_range_limiter_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       in_valid;
    logic [7:0] in_sample;
    logic       in_chroma;
    logic       in_vbi_pass;
    logic       cfg_wide;
    logic       line_start;
    logic       out_valid;
    logic [7:0] out_sample;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    vid_range_limiter u_vid_range_limiter (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_sample   (in_sample),
        .in_chroma   (in_chroma),
        .in_vbi_pass (in_vbi_pass),
        .cfg_wide    (cfg_wide),
        .line_start  (line_start),
        .out_valid   (out_valid),
        .out_sample  (out_sample)
    );

    // Vector layout: {wide, pass, chroma, sample[7:0], expected[7:0]}.
    localparam int NV = 24;
    localparam logic [18:0] VEC [NV] = '{
        {3'b000, 8'h00, 8'h10}, {3'b000, 8'h0F, 8'h10}, {3'b000, 8'h10, 8'h10},
        {3'b000, 8'h80, 8'h80}, {3'b000, 8'hEB, 8'hEB}, {3'b000, 8'hEC, 8'hEB},
        {3'b000, 8'hFF, 8'hEB}, {3'b001, 8'h05, 8'h10}, {3'b001, 8'hEC, 8'hEC},
        {3'b001, 8'hF0, 8'hF0}, {3'b001, 8'hF1, 8'hF0}, {3'b001, 8'hFF, 8'hF0},
        {3'b100, 8'h00, 8'h01}, {3'b100, 8'h01, 8'h01}, {3'b100, 8'h0F, 8'h0F},
        {3'b101, 8'hF5, 8'hF5}, {3'b101, 8'hFE, 8'hFE}, {3'b101, 8'hFF, 8'hFE},
        {3'b100, 8'hFF, 8'hFE}, {3'b010, 8'h05, 8'h05}, {3'b011, 8'hFA, 8'hFA},
        {3'b010, 8'h00, 8'h01}, {3'b110, 8'hFF, 8'hFE}, {3'b010, 8'hF5, 8'hF5}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // Drive one sample at the falling edge, sample the result one edge later.
    task automatic apply(input string req, input logic wide, input logic ls,
                         input logic pass, input logic chroma,
                         input logic [7:0] d, input logic [7:0] exp);
        @(negedge clk);
        in_valid = 1'b1; in_sample = d; in_chroma = chroma;
        in_vbi_pass = pass; cfg_wide = wide; line_start = ls;
        @(negedge clk);
        in_valid = 1'b0; line_start = 1'b0;
        check(req, out_sample, exp);
        check("R6", {7'd0, out_valid}, 8'd1);
        check("R5", {7'd0, (out_sample == 8'h00 || out_sample == 8'hFF)}, 8'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_sample = 8'h00; in_chroma = 1'b0;
        in_vbi_pass = 1'b0; cfg_wide = 1'b0; line_start = 1'b0;
        repeat (3) @(negedge clk);
        // R9: reset state of the outputs.
        check("R9", {7'd0, out_valid}, 8'd0);
        check("R9", out_sample, 8'h10);
        rst_n = 1'b1;
        // R9: mode after reset is narrow, so 0x05 luma without line_start -> 0x10.
        apply("R9", 1'b1, 1'b0, 1'b0, 1'b0, 8'h05, 8'h10);

        for (int i = 0; i < NV; i++) begin
            logic [18:0] v;
            string req;
            v = VEC[i];
            if (v[17])      req = "R4";
            else if (v[18]) req = "R3";
            else if (v[16]) req = "R2";
            else            req = "R1";
            apply(req, v[18], 1'b1, v[17], v[16], v[15:8], v[7:0]);
        end

        // R8: narrow loaded, then wide requested without line_start is ignored.
        apply("R8", 1'b0, 1'b1, 1'b0, 1'b0, 8'h80, 8'h80);
        apply("R8", 1'b1, 1'b0, 1'b0, 1'b0, 8'h05, 8'h10);
        apply("R8", 1'b1, 1'b1, 1'b0, 1'b0, 8'h05, 8'h05);
        apply("R8", 1'b0, 1'b0, 1'b0, 1'b0, 8'hF8, 8'hF8);
        apply("R8", 1'b0, 1'b1, 1'b0, 1'b0, 8'hF8, 8'hEB);

        // R7: idle cycle keeps the previous sample and drops valid (R6).
        @(negedge clk);
        in_valid = 1'b0; in_sample = 8'h40;
        @(negedge clk);
        check("R7", out_sample, 8'hEB);
        check("R6", {7'd0, out_valid}, 8'd0);
        @(negedge clk);
        check("R7", out_sample, 8'hEB);

        // R9: reset mid-stream restores the reset outputs and narrow mode.
        apply("R3", 1'b1, 1'b1, 1'b0, 1'b0, 8'h02, 8'h02);
        rst_n = 1'b0;
        @(negedge clk);
        check("R9", out_sample, 8'h10);
        check("R9", {7'd0, out_valid}, 8'd0);
        rst_n = 1'b1;
        apply("R9", 1'b1, 1'b0, 1'b0, 1'b1, 8'h02, 8'h10);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule